// File: doc/BRIEF.md
# Lockable clock channel register bank

This block keeps the configuration of 43 peripheral clock channels. Each channel word picks one of nine clock generators, carries an enable for that channel's clock, and holds a lock bit. Once the lock bit is set, the word is frozen and can only be cleared by a power reset. While a channel is locked it also asserts a lock toward the control register of the generator it selects, except for generator 0, which can never be locked. The neighbouring clock multiplexers and generator control registers take their settings from the per-channel outputs and the per-generator lock vector.

Software reaches the words through a word-addressed port. Writes are registered. Reads are combinational. An external write-protect input blocks all writes. There are two resets. The asynchronous power reset clears every channel. The synchronous user reset clears only the unlocked channels and never changes a lock bit.

Top module: `clk_chan_bank`

## Requirements
- R1: Channel m (0..42) sits at word address 0x20+m, which is byte offset 0x80+4*m. A read returns the lock bit at bit 7, the enable at bit 6 and the generator select at bits 3:0. Every other bit reads as zero.
- R2: An accepted write changes the stored word at the first rising clock edge where wr_en is high. ch_en[m] and ch_gen[4*m+3:4*m] show the stored enable and select of channel m directly.
- R3: After a channel's lock bit is 1, every write to that channel is discarded.
- R4: For n from 1 to 8, gen_lock[n] is high exactly when at least one locked channel selects generator n.
- R5: gen_lock[0] is always 0, even when a locked channel selects generator 0.
- R6: When pwr_rst_n is low, the select, enable and lock fields of every channel are cleared.
- R7: A user reset (usr_rst high at a clock edge) clears the select and enable of every unlocked channel. A locked channel keeps its whole word. No lock bit is changed. For an unlocked channel, the user reset takes priority over a write in the same cycle.
- R8: A write whose select field (bits 3:0) holds a reserved value from 0x9 to 0xF is dropped completely, and the stored word stays as it was.
- R9: While wr_prot is high, every write is discarded.
- R10: Reads of word addresses outside 0x20..0x4A return zero, and writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power reset, asynchronous, active low |
| usr_rst | input | 1 | User reset, synchronous, active high |
| wr_prot | input | 1 | Blocks all writes while high |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Word address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| ch_en | output | 43 | Enable of each channel |
| ch_gen | output | 172 | Generator select of each channel, 4 bits per channel |
| gen_lock | output | 9 | Lock request per generator |

## Verification
The checker watches four things on every clock cycle:
- A lock bit never falls outside a power reset.
- A locked word never moves.
- A protected write cycle leaves every word unchanged.
- Unlocked channels read back zero after a user reset, no stored select ever holds a reserved value, and out-of-range reads return zero.

Some behaviours can only be shown by the bench's scenarios, because they depend on the data and the order of writes:
- The bit layout that reads return.
- The exact lock-vector pattern for a given mix of channels.
- Generator 0 being exempt from locking.
- User reset taking priority over a simultaneous write.
- Writes working again after a power reset.

// File: rtl/clk_chan_pkg.sv
package clk_chan_pkg;
  localparam int GEN_W    = 4;
  localparam int WORD_W   = 32;
  localparam int LOCK_POS = 7;
  localparam int EN_POS   = 6;

  typedef struct packed {
    logic             lock;
    logic             en;
    logic [GEN_W-1:0] gen;
  } chan_cfg_t;

  function automatic logic [WORD_W-1:0] cfg_to_word(chan_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LOCK_POS]    = c.lock;
    w[EN_POS]      = c.en;
    w[GEN_W-1:0]   = c.gen;
    return w;
  endfunction
endpackage

// File: rtl/clk_chan_slot.sv
module clk_chan_slot
  import clk_chan_pkg::*;
#(
  parameter int NUM_GEN = 9
) (
  input  logic      clk,
  input  logic      pwr_rst_n,
  input  logic      usr_rst,
  input  logic      wr_hit,
  input  chan_cfg_t wr_cfg,
  output chan_cfg_t cfg_q
);
  localparam logic [GEN_W-1:0] GEN_MAX = GEN_W'(NUM_GEN - 1);

  chan_cfg_t cfg_d;
  logic      load;
  logic      gen_ok;
  logic      accept;
  logic      usr_clr;

  assign gen_ok  = (wr_cfg.gen <= GEN_MAX);
  assign accept  = wr_hit && !cfg_q.lock && gen_ok;
  assign usr_clr = usr_rst && !cfg_q.lock;

  always_comb begin
    cfg_d = cfg_q;
    load  = 1'b0;
    if (usr_clr) begin
      cfg_d = '0;
      load  = 1'b1;
    end else if (accept) begin
      cfg_d = wr_cfg;
      load  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/clk_chan_lockmap.sv
module clk_chan_lockmap
  import clk_chan_pkg::*;
#(
  parameter int NUM_CH  = 43,
  parameter int NUM_GEN = 9
) (
  input  chan_cfg_t          cfg [NUM_CH],
  output logic [NUM_GEN-1:0] gen_lock
);
  assign gen_lock[0] = 1'b0;

  for (genvar n = 1; n < NUM_GEN; n++) begin : g_gen
    always_comb begin
      gen_lock[n] = 1'b0;
      for (int m = 0; m < NUM_CH; m++) begin
        if (cfg[m].lock && (cfg[m].gen == GEN_W'(n))) begin
          gen_lock[n] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clk_chan_rdmux.sv
module clk_chan_rdmux
  import clk_chan_pkg::*;
#(
  parameter int NUM_CH = 43
) (
  input  chan_cfg_t          cfg [NUM_CH],
  input  logic [NUM_CH-1:0]  sel,
  output logic [WORD_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    for (int m = 0; m < NUM_CH; m++) begin
      if (sel[m]) begin
        rdata = cfg_to_word(cfg[m]);
      end
    end
  end
endmodule

// File: rtl/clk_chan_bank.sv
module clk_chan_bank
  import clk_chan_pkg::*;
#(
  parameter int NUM_CH    = 43,
  parameter int NUM_GEN   = 9,
  parameter int ADDR_W    = 8,
  parameter int BASE_WORD = 32
) (
  input  logic                    clk,
  input  logic                    pwr_rst_n,
  input  logic                    usr_rst,
  input  logic                    wr_prot,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORD_W-1:0]       rdata,
  output logic [NUM_CH-1:0]       ch_en,
  output logic [NUM_CH*GEN_W-1:0] ch_gen,
  output logic [NUM_GEN-1:0]      gen_lock
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_WORD);

  logic [ADDR_W-1:0] offs;
  logic              in_range;
  logic [NUM_CH-1:0] sel;
  logic [NUM_CH-1:0] ch_lock;
  logic              wr_go;
  chan_cfg_t         wr_cfg;
  chan_cfg_t         cfg [NUM_CH];
  logic              unused_wbits;

  assign offs     = addr - BASE_A;
  assign in_range = (addr >= BASE_A) && (offs < ADDR_W'(NUM_CH));
  assign wr_go    = wr_en && !wr_prot;

  assign wr_cfg.lock = wdata[LOCK_POS];
  assign wr_cfg.en   = wdata[EN_POS];
  assign wr_cfg.gen  = wdata[GEN_W-1:0];
  assign unused_wbits = ^{wdata[WORD_W-1:LOCK_POS+1], wdata[EN_POS-1:GEN_W]};

  for (genvar m = 0; m < NUM_CH; m++) begin : g_ch
    assign sel[m] = in_range && (offs == ADDR_W'(m));

    clk_chan_slot #(.NUM_GEN(NUM_GEN)) u_slot (
      .clk       (clk),
      .pwr_rst_n (pwr_rst_n),
      .usr_rst   (usr_rst),
      .wr_hit    (wr_go && sel[m]),
      .wr_cfg    (wr_cfg),
      .cfg_q     (cfg[m])
    );

    assign ch_en[m]                 = cfg[m].en;
    assign ch_gen[m*GEN_W +: GEN_W] = cfg[m].gen;
    assign ch_lock[m]               = cfg[m].lock;
  end

  clk_chan_lockmap #(.NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN)) u_lockmap (
    .cfg      (cfg),
    .gen_lock (gen_lock)
  );

  clk_chan_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
    .cfg   (cfg),
    .sel   (sel),
    .rdata (rdata)
  );
endmodule

// File: rtl/clk_chan_bank_chk.sv
module clk_chan_bank_chk #(
  parameter int NUM_CH    = 43,
  parameter int NUM_GEN   = 9,
  parameter int ADDR_W    = 8,
  parameter int BASE_WORD = 32,
  parameter int GEN_W     = 4
) (
  input logic                    clk,
  input logic                    pwr_rst_n,
  input logic                    usr_rst,
  input logic                    wr_prot,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             rdata,
  input logic [NUM_CH-1:0]       ch_en,
  input logic [NUM_CH*GEN_W-1:0] ch_gen,
  input logic [NUM_CH-1:0]       ch_lock
);
  logic out_of_range;
  assign out_of_range = (int'(addr) < BASE_WORD) || (int'(addr) >= BASE_WORD + NUM_CH);

  AST_PROT_FREEZE: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    $past(wr_prot) && !$past(usr_rst) |-> $stable({ch_lock, ch_en, ch_gen})); // R9

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    out_of_range |-> (rdata == 32'd0)); // R10

  for (genvar m = 0; m < NUM_CH; m++) begin : g_ch
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      $past(ch_lock[m]) |-> ch_lock[m]); // R7

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      $past(ch_lock[m]) |-> $stable(ch_en[m]) && $stable(ch_gen[m*GEN_W +: GEN_W])); // R3

    AST_USER_CLEAR: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      $past(usr_rst) && !$past(ch_lock[m]) |-> !ch_en[m] && (ch_gen[m*GEN_W +: GEN_W] == '0)); // R7

    AST_NO_RESERVED_GEN: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      int'(ch_gen[m*GEN_W +: GEN_W]) < NUM_GEN); // R8
  end
endmodule

bind clk_chan_bank clk_chan_bank_chk #(
  .NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W),
  .BASE_WORD(BASE_WORD), .GEN_W(clk_chan_pkg::GEN_W)
) u_chk (
  .clk       (clk),
  .pwr_rst_n (pwr_rst_n),
  .usr_rst   (usr_rst),
  .wr_prot   (wr_prot),
  .addr      (addr),
  .rdata     (rdata),
  .ch_en     (ch_en),
  .ch_gen    (ch_gen),
  .ch_lock   (ch_lock)
);

// File: tb/test_clk_chan_bank.sv
`timescale 1ns/1ps
module test_clk_chan_bank;
  logic         clk = 1'b0;
  logic         pwr_rst_n = 1'b0;
  logic         usr_rst = 1'b0;
  logic         wr_prot = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [42:0]  ch_en;
  logic [171:0] ch_gen;
  logic [8:0]   gen_lock;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_chan_bank i_clk_chan_bank (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .usr_rst(usr_rst), .wr_prot(wr_prot),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ch_en(ch_en), .ch_gen(ch_gen), .gen_lock(gen_lock)
  );

  // {is_write, addr, data}; for reads data is the expected value
  localparam int NV = 13;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h20, 32'h0000_0045},   // R2 enable, gen 5
    {1'b0, 8'h20, 32'h0000_0045},
    {1'b1, 8'h21, 32'h0000_004F},   // R8 reserved select dropped
    {1'b0, 8'h21, 32'h0000_0000},
    {1'b1, 8'h21, 32'h0000_00C3},   // lock + enable, gen 3
    {1'b0, 8'h21, 32'h0000_00C3},
    {1'b1, 8'h21, 32'h0000_0041},   // R3 locked, dropped
    {1'b0, 8'h21, 32'h0000_00C3},
    {1'b1, 8'h4A, 32'hFFFF_FF78},   // R1 unused bits masked
    {1'b0, 8'h4A, 32'h0000_0048},
    {1'b1, 8'h4B, 32'h0000_0041},   // R10 out of range
    {1'b0, 8'h4B, 32'h0000_0000},
    {1'b0, 8'h1F, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    pwr_rst_n = 1'b1;
    // R6 reset state
    read_check("R6", 8'h20, 32'h0);
    check("R6", {23'b0, gen_lock}, 32'h0);
    check("R6", {21'b0, ch_en[10:0]}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) do_write(VEC[i][39:32], VEC[i][31:0]);
      else read_check("R1_R2_R3_R8_R10", VEC[i][39:32], VEC[i][31:0]);
    end

    // R2 direct outputs
    check("R2", {30'b0, ch_en[42], ch_en[0]}, 32'h3);
    check("R2", {24'b0, ch_gen[171:168], ch_gen[3:0]}, 32'h85);
    // R4 channel 1 locked on gen 3
    check("R4", {23'b0, gen_lock}, 32'h008);
    // R5 locked channel on gen 0
    do_write(8'h22, 32'h80);
    read_check("R5", 8'h22, 32'h80);
    check("R5", {23'b0, gen_lock}, 32'h008);
    // R9 write protect
    @(negedge clk); wr_prot = 1'b1;
    do_write(8'h23, 32'h47);
    @(negedge clk); wr_prot = 1'b0;
    read_check("R9", 8'h23, 32'h0);
    // R7 user reset with simultaneous write to an unlocked channel
    @(negedge clk);
    usr_rst = 1'b1; wr_en = 1'b1; addr = 8'h24; wdata = 32'h41;
    @(negedge clk);
    usr_rst = 1'b0; wr_en = 1'b0;
    read_check("R7", 8'h24, 32'h0);
    read_check("R7", 8'h20, 32'h0);
    read_check("R7", 8'h4A, 32'h0);
    read_check("R7", 8'h21, 32'hC3);
    read_check("R7", 8'h22, 32'h80);
    check("R7", {23'b0, gen_lock}, 32'h008);
    // R6 power reset clears locked channels
    @(negedge clk); pwr_rst_n = 1'b0;
    @(negedge clk); pwr_rst_n = 1'b1;
    read_check("R6", 8'h21, 32'h0);
    check("R6", {23'b0, gen_lock}, 32'h0);
    do_write(8'h21, 32'h42);
    read_check("R6", 8'h21, 32'h42);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule